// File: doc/BRIEF.md
# Internal Data Space Router

This block sits between a small 8-bit controller core and its on-chip 256-location data space. Each cycle the core presents one byte address together with flags that say whether the access is direct or indirect, and whether it is a whole-byte or a single-bit operation. It also raises a read or a write strobe. The router works out where the access lands: the lower RAM, the hidden upper RAM, the special-function-register (SFR) port, or nowhere. It then moves the data, and it carries out single-bit writes as a read-modify-write inside the same cycle.

Working registers are reached through a separate selector. When that selector is raised, a register index together with a bank number picks a byte in the lower RAM, and the address input plays no part. A parameter chooses between two builds. The basic build has 128 bytes of RAM, and its upper half of the map serves only SFRs. The extended build adds 128 bytes that only indirect accesses can reach. The SFR storage lives outside the block, behind a plain port with a combinational read.

Top module: `idata_router`

## Requirements
- R1: Byte addresses 0x00–0x7F read and write the lower RAM in both direct and indirect mode, and leave `sfr_rd` and `sfr_wr` low.
- R2: A direct byte access to 0x80–0xFF drives `sfr_addr` with the address and raises `sfr_rd` for a read or `sfr_wr` for a write, with `sfr_wdata` equal to `wdata`. A read returns `sfr_rdata`.
- R3: In the extended build (EXTENDED=1), an indirect byte access to 0x80–0xFF reads and writes a separate 128-byte RAM. That RAM is distinct from the SFR at the same address, and the access leaves the SFR port idle.
- R4: In the basic build (EXTENDED=0), an indirect byte access to 0x80–0xFF reads 0xFF, changes no storage and leaves the SFR port idle.
- R5: Bit address n in 0x00–0x7F selects bit (n mod 8) of lower-RAM byte 0x20 + n/8. A bit read returns the bit in `rdata[0]`, with `rdata[7:1]` zero.
- R6: Bit address n in 0x80–0xFF selects bit (n mod 8) of the SFR at address n with its three low bits cleared.
- R7: A bit write takes the new bit value from `wdata[0]` and writes back the containing byte with the other seven bits unchanged, all in the cycle of the strobe. For an SFR target, `sfr_rd` and `sfr_wr` are both high in that cycle, and `sfr_wdata` is `sfr_rdata` with the one bit replaced.
- R8: With `use_reg` high, the access goes to lower-RAM byte `bank_sel`*8 + `reg_idx` as a byte access, whatever `addr`, `is_indirect` and `is_bit` hold.
- R9: `rd_valid` is high in the cycle after a cycle with `rd_en` high and low otherwise. `rdata` then holds the read result and keeps it until the next read.
- R10: After reset, `rd_valid` and `rdata` are 0 and every RAM byte reads 0.
- R11: Bit accesses ignore `is_indirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| is_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| is_bit | input | 1 | 1 = single-bit access, `addr` is a bit address |
| addr | input | ADDR_W (8) | Byte or bit address |
| wdata | input | DATA_W (8) | Write byte, or new bit value in bit 0 |
| use_reg | input | 1 | Access a working register instead of `addr` |
| reg_idx | input | log2(BANK_REGS) (3) | Working register number |
| bank_sel | input | log2(NUM_BANKS) (2) | Active register bank |
| rdata | output | DATA_W (8) | Registered read result |
| rd_valid | output | 1 | `rdata` updated by the previous cycle's read |
| sfr_addr | output | ADDR_W (8) | SFR byte address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | DATA_W (8) | SFR write byte |
| sfr_rdata | input | DATA_W (8) | SFR read byte, combinational from `sfr_addr` |

## Verification
The hardest case to reach from the ports is one upper-half address that holds three unrelated values at once: an SFR, a hidden RAM byte, and a bit view of that same SFR. The stimulus writes different bytes to 0x90 through the direct path and the indirect path. It then changes one bit through the bit map and reads all three views back, so that any mix-up between SFR and hidden RAM shows up as a wrong byte. A basic-build copy receives the same stimulus with its own SFR model. Its SFR must show only the direct and bit traffic, and its indirect upper reads must return 0xFF.

// File: rtl/idata_pkg.sv
`timescale 1ns/1ps
package idata_pkg;

   localparam int IDATA_AW = 8;
   localparam int IDATA_DW = 8;

   typedef enum logic [1:0] {
      TGT_LO   = 2'd0,
      TGT_HI   = 2'd1,
      TGT_SFR  = 2'd2,
      TGT_VOID = 2'd3
   } tgt_e;

   typedef struct packed {
      tgt_e                tgt;
      logic [IDATA_AW-1:0] loc;
      logic [2:0]          bit_pos;
      logic                bit_op;
   } decode_t;

endpackage

// File: rtl/idata_addr_map.sv
`timescale 1ns/1ps
module idata_addr_map
   import idata_pkg::*;
#(
   parameter int          ADDR_W        = 8,
   parameter int          NUM_BANKS     = 4,
   parameter int          BANK_REGS     = 8,
   parameter logic [7:0]  BIT_AREA_BASE = 8'h20,
   parameter bit          EXTENDED      = 1'b1,
   localparam int         BANK_W        = $clog2(NUM_BANKS),
   localparam int         REG_W         = $clog2(BANK_REGS),
   localparam int         MSB           = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_indirect,
   input  logic              is_bit,
   input  logic              use_reg,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [BANK_W-1:0] bank_sel,
   output decode_t           dec
);

   localparam tgt_e UPPER_IND_TGT = EXTENDED ? TGT_HI : TGT_VOID;

   always_comb begin
      dec         = '0;
      dec.tgt     = TGT_LO;
      dec.bit_pos = addr[2:0];
      if (use_reg) begin
         dec.loc = ADDR_W'(int'(bank_sel) * BANK_REGS + int'(reg_idx));
      end else if (is_bit) begin
         dec.bit_op = 1'b1;
         if (!addr[MSB]) begin
            dec.loc = BIT_AREA_BASE + ADDR_W'(addr[MSB-1:3]);
         end else begin
            dec.tgt = TGT_SFR;
            dec.loc = {addr[MSB:3], 3'b000};
         end
      end else begin
         dec.loc = addr;
         if (addr[MSB]) begin
            dec.tgt = is_indirect ? UPPER_IND_TGT : TGT_SFR;
         end
      end
   end

endmodule

// File: rtl/idata_ram.sv
`timescale 1ns/1ps
module idata_ram #(
   parameter int  DEPTH  = 128,
   parameter int  DATA_W = 8,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   assign rdata = mem[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wdata;
      end
   end

endmodule

// File: rtl/idata_bit_merge.sv
`timescale 1ns/1ps
module idata_bit_merge #(
   parameter int  DATA_W = 8,
   localparam int POS_W  = $clog2(DATA_W)
) (
   input  logic              bit_op,
   input  logic [POS_W-1:0]  bit_pos,
   input  logic [DATA_W-1:0] old_byte,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] wr_byte,
   output logic [DATA_W-1:0] rd_val
);

   logic [DATA_W-1:0] sel_mask;

   assign sel_mask = DATA_W'(1) << bit_pos;

   always_comb begin
      if (bit_op) begin
         wr_byte = (old_byte & ~sel_mask) | (wdata[0] ? sel_mask : '0);
         rd_val  = DATA_W'(old_byte[bit_pos]);
      end else begin
         wr_byte = wdata;
         rd_val  = old_byte;
      end
   end

endmodule

// File: rtl/idata_router.sv
`timescale 1ns/1ps
module idata_router
   import idata_pkg::*;
#(
   parameter int         ADDR_W        = 8,
   parameter int         DATA_W        = 8,
   parameter int         NUM_BANKS     = 4,
   parameter int         BANK_REGS     = 8,
   parameter logic [7:0] BIT_AREA_BASE = 8'h20,
   parameter bit         EXTENDED      = 1'b1,
   localparam int        HALF_DEPTH    = 2 ** (ADDR_W - 1),
   localparam int        HALF_W        = ADDR_W - 1,
   localparam int        BANK_W        = $clog2(NUM_BANKS),
   localparam int        REG_W         = $clog2(BANK_REGS),
   localparam int        BIT_BYTES     = HALF_DEPTH / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              is_indirect,
   input  logic              is_bit,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              use_reg,
   input  logic [REG_W-1:0]  reg_idx,
   input  logic [BANK_W-1:0] bank_sel,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] sfr_addr,
   output logic              sfr_rd,
   output logic              sfr_wr,
   output logic [DATA_W-1:0] sfr_wdata,
   input  logic [DATA_W-1:0] sfr_rdata
);

   // elaboration-time parameter checks
   if (ADDR_W != IDATA_AW) begin : g_bad_aw
      $error("idata_router: ADDR_W must be %0d", IDATA_AW);
   end
   if (DATA_W != IDATA_DW) begin : g_bad_dw
      $error("idata_router: DATA_W must be %0d", IDATA_DW);
   end
   if (NUM_BANKS * BANK_REGS > int'(BIT_AREA_BASE)) begin : g_bad_banks
      $error("idata_router: register banks overlap the bit area");
   end
   if (int'(BIT_AREA_BASE) + BIT_BYTES > HALF_DEPTH) begin : g_bad_bitarea
      $error("idata_router: bit area exceeds lower RAM");
   end

   decode_t           dec;
   logic [DATA_W-1:0] lo_rdata;
   logic [DATA_W-1:0] hi_rdata;
   logic [DATA_W-1:0] old_byte;
   logic [DATA_W-1:0] wr_byte;
   logic [DATA_W-1:0] rd_val;
   logic              lo_we;
   logic              hi_we;
   logic              to_sfr;

   idata_addr_map #(
      .ADDR_W        (ADDR_W),
      .NUM_BANKS     (NUM_BANKS),
      .BANK_REGS     (BANK_REGS),
      .BIT_AREA_BASE (BIT_AREA_BASE),
      .EXTENDED      (EXTENDED)
   ) u_map (
      .addr        (addr),
      .is_indirect (is_indirect),
      .is_bit      (is_bit),
      .use_reg     (use_reg),
      .reg_idx     (reg_idx),
      .bank_sel    (bank_sel),
      .dec         (dec)
   );

   assign lo_we  = wr_en && (dec.tgt == TGT_LO);
   assign hi_we  = wr_en && (dec.tgt == TGT_HI);
   assign to_sfr = (dec.tgt == TGT_SFR);

   idata_ram #(.DEPTH(HALF_DEPTH), .DATA_W(DATA_W)) u_lo_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (lo_we),
      .idx   (dec.loc[HALF_W-1:0]),
      .wdata (wr_byte),
      .rdata (lo_rdata)
   );

   if (EXTENDED) begin : g_hi_ram
      idata_ram #(.DEPTH(HALF_DEPTH), .DATA_W(DATA_W)) u_hi_ram (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (hi_we),
         .idx   (dec.loc[HALF_W-1:0]),
         .wdata (wr_byte),
         .rdata (hi_rdata)
      );
   end else begin : g_no_hi_ram
      assign hi_rdata = '1;
   end

   always_comb begin
      unique case (dec.tgt)
         TGT_LO:  old_byte = lo_rdata;
         TGT_HI:  old_byte = hi_rdata;
         TGT_SFR: old_byte = sfr_rdata;
         default: old_byte = '1;
      endcase
   end

   idata_bit_merge #(.DATA_W(DATA_W)) u_merge (
      .bit_op   (dec.bit_op),
      .bit_pos  (dec.bit_pos),
      .old_byte (old_byte),
      .wdata    (wdata),
      .wr_byte  (wr_byte),
      .rd_val   (rd_val)
   );

   assign sfr_addr  = dec.loc;
   assign sfr_rd    = to_sfr && (rd_en || (wr_en && dec.bit_op));
   assign sfr_wr    = to_sfr && wr_en;
   assign sfr_wdata = wr_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_val;
      end
   end

endmodule

// File: rtl/idata_router_chk.sv
`timescale 1ns/1ps
module idata_router_chk #(
   parameter bit EXTENDED = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_en,
   input logic       wr_en,
   input logic       is_indirect,
   input logic       is_bit,
   input logic [7:0] addr,
   input logic       use_reg,
   input logic [7:0] rdata,
   input logic       rd_valid,
   input logic [7:0] sfr_addr,
   input logic       sfr_rd,
   input logic       sfr_wr,
   input logic [7:0] sfr_wdata,
   input logic [7:0] sfr_rdata
);

   logic       acc;
   logic       plain;
   logic [7:0] keep_mask;

   assign acc       = rd_en || wr_en;
   assign plain     = !is_bit && !use_reg;
   assign keep_mask = ~(8'h01 << addr[2:0]);

   AST_LOW_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
      acc && plain && !addr[7] |-> !sfr_rd && !sfr_wr); // R1

   AST_DIRECT_SFR_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && plain && addr[7] && !is_indirect |-> sfr_rd && sfr_addr == addr); // R2

   AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
      acc && plain && addr[7] && is_indirect |-> !sfr_rd && !sfr_wr); // R3

   AST_BIT_SFR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      acc && is_bit && !use_reg && addr[7] |-> sfr_addr == {addr[7:3], 3'b000}); // R6

   AST_BIT_RMW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && is_bit && !use_reg && addr[7]
      |-> sfr_rd && sfr_wr && ((sfr_wdata & keep_mask) == (sfr_rdata & keep_mask))); // R7

   AST_RD_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R9

   AST_RD_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid); // R9

   AST_BIT_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && is_bit && !use_reg |=> rdata[7:1] == 7'd0); // R5

   if (!EXTENDED) begin : g_basic
      AST_VOID_READ: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en && plain && addr[7] && is_indirect |=> rdata == 8'hFF); // R4
   end

endmodule

bind idata_router idata_router_chk #(.EXTENDED(EXTENDED)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .wr_en       (wr_en),
   .is_indirect (is_indirect),
   .is_bit      (is_bit),
   .addr        (addr),
   .use_reg     (use_reg),
   .rdata       (rdata),
   .rd_valid    (rd_valid),
   .sfr_addr    (sfr_addr),
   .sfr_rd      (sfr_rd),
   .sfr_wr      (sfr_wr),
   .sfr_wdata   (sfr_wdata),
   .sfr_rdata   (sfr_rdata)
);

// File: tb/idata_router_tb.sv
`timescale 1ns/1ps
module idata_router_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0, wr_en = 1'b0, is_indirect = 1'b0, is_bit = 1'b0, use_reg = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [2:0] reg_idx = '0;
   logic [1:0] bank_sel = '0;

   logic [7:0] rdata_x, sfr_addr_x, sfr_wdata_x, sfr_rdata_x;
   logic       rd_valid_x, sfr_rd_x, sfr_wr_x;
   logic [7:0] rdata_b, sfr_addr_b, sfr_wdata_b, sfr_rdata_b;
   logic       rd_valid_b, sfr_rd_b, sfr_wr_b;

   logic [7:0] sfr_mem_x [128];
   logic [7:0] sfr_mem_b [128];

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic       c_rd, c_wr, cb_rd, cb_wr;
   logic [7:0] c_addr, c_wdata;

   always #2 clk = ~clk;

   idata_router #(.EXTENDED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .is_indirect(is_indirect), .is_bit(is_bit), .addr(addr), .wdata(wdata),
      .use_reg(use_reg), .reg_idx(reg_idx), .bank_sel(bank_sel),
      .rdata(rdata_x), .rd_valid(rd_valid_x), .sfr_addr(sfr_addr_x),
      .sfr_rd(sfr_rd_x), .sfr_wr(sfr_wr_x), .sfr_wdata(sfr_wdata_x),
      .sfr_rdata(sfr_rdata_x)
   );

   idata_router #(.EXTENDED(1'b0)) u_dut_basic (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .is_indirect(is_indirect), .is_bit(is_bit), .addr(addr), .wdata(wdata),
      .use_reg(use_reg), .reg_idx(reg_idx), .bank_sel(bank_sel),
      .rdata(rdata_b), .rd_valid(rd_valid_b), .sfr_addr(sfr_addr_b),
      .sfr_rd(sfr_rd_b), .sfr_wr(sfr_wr_b), .sfr_wdata(sfr_wdata_b),
      .sfr_rdata(sfr_rdata_b)
   );

   // SFR models: combinational read, clocked write
   assign sfr_rdata_x = sfr_mem_x[sfr_addr_x[6:0]];
   assign sfr_rdata_b = sfr_mem_b[sfr_addr_b[6:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) begin
            sfr_mem_x[i] <= '0;
            sfr_mem_b[i] <= '0;
         end
      end else begin
         if (sfr_wr_x) sfr_mem_x[sfr_addr_x[6:0]] <= sfr_wdata_x;
         if (sfr_wr_b) sfr_mem_b[sfr_addr_b[6:0]] <= sfr_wdata_b;
      end
   end

   // vector: {write, indirect, bit, addr, data}; data is write data or expected read
   localparam int NV = 21;
   localparam logic [18:0] VECS [NV] = '{
      {1'b1, 1'b0, 1'b0, 8'h10, 8'h5A},  // R1
      {1'b0, 1'b0, 1'b0, 8'h10, 8'h5A},  // R1
      {1'b0, 1'b1, 1'b0, 8'h10, 8'h5A},  // R1
      {1'b1, 1'b0, 1'b0, 8'h90, 8'h33},  // R2
      {1'b1, 1'b1, 1'b0, 8'h90, 8'hC4},  // R3
      {1'b0, 1'b0, 1'b0, 8'h90, 8'h33},  // R2
      {1'b0, 1'b1, 1'b0, 8'h90, 8'hC4},  // R3
      {1'b1, 1'b0, 1'b0, 8'h2F, 8'h00},  // R5
      {1'b1, 1'b0, 1'b1, 8'h7B, 8'h01},  // R7
      {1'b0, 1'b0, 1'b0, 8'h2F, 8'h08},  // R7
      {1'b0, 1'b0, 1'b1, 8'h7B, 8'h01},  // R5
      {1'b1, 1'b0, 1'b0, 8'h21, 8'hFF},  // R7
      {1'b1, 1'b0, 1'b1, 8'h0A, 8'h00},  // R7
      {1'b0, 1'b0, 1'b0, 8'h21, 8'hFB},  // R7
      {1'b1, 1'b0, 1'b1, 8'h95, 8'h00},  // R6
      {1'b0, 1'b0, 1'b0, 8'h90, 8'h13},  // R6
      {1'b0, 1'b0, 1'b1, 8'h94, 8'h01},  // R6
      {1'b0, 1'b1, 1'b0, 8'h90, 8'hC4},  // R3
      {1'b0, 1'b1, 1'b1, 8'h7B, 8'h01},  // R11
      {1'b1, 1'b1, 1'b1, 8'h01, 8'h01},  // R11
      {1'b0, 1'b0, 1'b0, 8'h20, 8'h02}   // R11
   };
   string vtag [NV] = '{"R1", "R1", "R1", "R2", "R3", "R2", "R3", "R5", "R7", "R7", "R5",
                        "R7", "R7", "R7", "R6", "R6", "R6", "R3", "R11", "R11", "R11"};

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // one access: drive at negedge, capture strobes, result visible at next negedge
   task automatic access(input logic w, input logic ind, input logic b, input logic ur,
                         input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      rd_en = !w; wr_en = w; is_indirect = ind; is_bit = b; use_reg = ur;
      addr = a; wdata = d;
      #1;
      c_rd = sfr_rd_x; c_wr = sfr_wr_x; c_addr = sfr_addr_x; c_wdata = sfr_wdata_x;
      cb_rd = sfr_rd_b; cb_wr = sfr_wr_b;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0; use_reg = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check8("R10 rd_valid", 8'(rd_valid_x), 8'h00);
      check8("R10 rdata", rdata_x, 8'h00);
      rst_n = 1'b1;
      access(1'b0, 1'b0, 1'b0, 1'b0, 8'h45, 8'h00);
      check8("R10 RAM zero", rdata_x, 8'h00);
      check8("R9 rd_valid after read", 8'(rd_valid_x), 8'h01);

      for (int i = 0; i < NV; i++) begin
         access(VECS[i][18], VECS[i][17], VECS[i][16], 1'b0, VECS[i][15:8], VECS[i][7:0]);
         if (!VECS[i][18]) check8($sformatf("%s table[%0d]", vtag[i], i), rdata_x, VECS[i][7:0]);
      end

      // R9: write cycle leaves rd_valid low, rdata held
      access(1'b1, 1'b0, 1'b0, 1'b0, 8'h30, 8'hE1);
      check8("R9 rd_valid after write", 8'(rd_valid_x), 8'h00);
      check8("R9 rdata held", rdata_x, 8'h02);
      check8("R1 no SFR strobe", {6'd0, c_rd, c_wr}, 8'h00);

      // R2: direct SFR write strobes
      access(1'b1, 1'b0, 1'b0, 1'b0, 8'h88, 8'h66);
      check8("R2 sfr_wr", 8'(c_wr), 8'h01);
      check8("R2 sfr_addr", c_addr, 8'h88);
      check8("R2 sfr_wdata", c_wdata, 8'h66);

      // R7: SFR bit write, bit 3 of 0x88 set
      access(1'b1, 1'b0, 1'b1, 1'b0, 8'h8B, 8'h01);
      check8("R7 sfr rd+wr", {6'd0, c_rd, c_wr}, 8'h03);
      check8("R7 sfr_wdata", c_wdata, 8'h6E);
      access(1'b0, 1'b0, 1'b0, 1'b0, 8'h88, 8'h00);
      check8("R7 sfr readback", rdata_x, 8'h6E);

      // R3 / R4: indirect upper write
      access(1'b1, 1'b1, 1'b0, 1'b0, 8'h98, 8'h55);
      check8("R4 basic SFR idle", {6'd0, cb_rd, cb_wr}, 8'h00);
      check8("R3 ext SFR idle", {6'd0, c_rd, c_wr}, 8'h00);
      access(1'b0, 1'b1, 1'b0, 1'b0, 8'h98, 8'h00);
      check8("R3 hidden RAM", rdata_x, 8'h55);
      check8("R4 basic indirect read", rdata_b, 8'hFF);
      access(1'b0, 1'b0, 1'b0, 1'b0, 8'h98, 8'h00);
      check8("R4 basic SFR untouched", rdata_b, 8'h00);
      check8("R3 ext SFR untouched", rdata_x, 8'h00);
      access(1'b0, 1'b0, 1'b0, 1'b0, 8'h90, 8'h00);
      check8("R4 basic SFR direct/bit only", rdata_b, 8'h13);

      // R8: working registers
      bank_sel = 2'd2; reg_idx = 3'd5;
      access(1'b1, 1'b1, 1'b1, 1'b1, 8'hC3, 8'hA7);
      access(1'b0, 1'b0, 1'b0, 1'b0, 8'h15, 8'h00);
      check8("R8 bank2 R5 at 0x15", rdata_x, 8'hA7);
      access(1'b0, 1'b0, 1'b0, 1'b1, 8'h90, 8'h00);
      check8("R8 register read", rdata_x, 8'hA7);
      bank_sel = 2'd0;
      access(1'b0, 1'b0, 1'b0, 1'b1, 8'h15, 8'h00);
      check8("R8 bank0 R5", rdata_x, 8'h00);
      bank_sel = 2'd3; reg_idx = 3'd7;
      access(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h3C);
      access(1'b0, 1'b0, 1'b0, 1'b0, 8'h1F, 8'h00);
      check8("R8 bank3 R7 at 0x1F", rdata_x, 8'h3C);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule